// File: doc/BRIEF.md
# Simultaneous-Sample Channel-Subset Sequencer

This block is the digital control core of a four-channel converter that samples all of its inputs at one instant. A rising edge on the start input puts every sample-and-hold into hold in the same clock cycle. It also captures the four incoming channel words at that edge. The block latches the subset of channels to convert, then works through only those channels in ascending order. Each channel takes a fixed number of clock cycles.

A one-cycle end-of-conversion strobe marks each finished channel. A busy flag covers the whole sequence. When busy drops, the holds return to tracking. The subset comes either from four select pins or from an internal select register, chosen by a mode input. The select register is written over the low data bits with an active-low chip-select/write cycle.

Results are held in order of conversion. Successive active-low chip-select/read cycles return them one after another. The analog path and the bit-by-bit conversion sit outside the block: each channel's held 14-bit value arrives on an input port.

Top module: `simseq_ctrl`

## Requirements
- R1: On the first clock edge at which `convst` is high after having been low, with `busy` low, `busy` goes to 1 and all bits of `hold` go to 1 (1 = hold, 0 = track).
- R2: With `hw_sel` = 0 the subset is `sel_pin`; with `hw_sel` = 1 it is the select register. In both cases bit i enables channel i.
- R3: The subset is latched at the start edge. Changes to `sel_pin`, `hw_sel` or the register made after that edge affect only the next sequence.
- R4: Enabled channels convert in ascending index order, each for `CONV_CYC` cycles. `eoc` is high for exactly one cycle after the n-th channel, n·`CONV_CYC` clock edges after the start edge.
- R5: `busy` falls in the same cycle as the last `eoc` pulse, and all `hold` bits return to 0 with it.
- R6: With an empty subset, `busy` is high for one cycle, no `eoc` occurs, and the holds return to track.
- R7: A rising edge on `convst` while `busy` is high is ignored: timing, subset and results of the running sequence are unchanged, and no new sequence follows.
- R8: Each result equals the channel word on `ch_in` at the start edge, whatever `ch_in` does afterwards. Channel i occupies bits [14i+13:14i].
- R9: While `cs_n` and `rd_n` are both low, `rd_data` shows the next stored result of the current sequence. The read pointer advances when the read ends and resets at each start edge. Reads past the last result return 0, and `rd_data` is 0 when no read is active.
- R10: A cycle with `cs_n` and `wr_n` both low, following one where they were not, loads `db_in[3:0]` into the select register.
- R11: Reset sets the select register to 4'b1111, clears `busy` and `eoc`, and sets all `hold` bits to track (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst | input | 1 | Conversion start; rising edge starts a sequence |
| hw_sel | input | 1 | Subset source: 0 pins, 1 select register |
| sel_pin | input | 4 | Channel enable pins, bit i = channel i |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| wr_n | input | 1 | Active-low write |
| db_in | input | 14 | Write data; low four bits load the select register |
| ch_in | input | 56 | Four 14-bit channel words, channel 0 in the low bits |
| rd_data | output | 14 | Read data |
| busy | output | 1 | High for the whole conversion sequence |
| eoc | output | 1 | One-cycle strobe after each channel |
| hold | output | 4 | Per-channel hold flag, 1 = hold |

## Verification
The bench changes `ch_in`, the pins and the select register right after the start edge. A design that sampled late, or that read the subset during the sequence, returns wrong words or the wrong number of `eoc` pulses. It pulses `convst` in mid-sequence: a design that restarts stretches `busy` or resets the read pointer. It runs an empty subset, where a design without a guard would hang busy high or emit a spurious strobe. It reads past the last result, which a loose pointer answers with stale data instead of zero. It also checks the reset value of the select register by starting in register mode without any write, expecting all four channels.

// File: rtl/simseq_ctrl.sv
module simseq_ctrl #(
  parameter int CH       = 4,
  parameter int DW       = 14,
  parameter int CONV_CYC = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convst,
  input  logic             hw_sel,
  input  logic [CH-1:0]    sel_pin,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [DW-1:0]    db_in,
  input  logic [CH*DW-1:0] ch_in,
  output logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic             eoc,
  output logic [CH-1:0]    hold
);
  localparam int CW = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
  localparam int PW = $clog2(CH + 1);
  localparam int IW = (CH > 1) ? $clog2(CH) : 1;
  localparam logic [CW-1:0] TLAST = CW'(CONV_CYC - 1);

  logic          convst_q, rd_q, wr_q;
  logic [CH-1:0] sel_reg, pend, pend_nxt;
  logic [CW-1:0] tmr;
  logic [PW-1:0] nres, rptr;
  logic [IW-1:0] cur;
  logic [DW-1:0] smp [CH];
  logic [DW-1:0] res [CH];

  wire rd_act = ~cs_n & ~rd_n;
  wire wr_act = ~cs_n & ~wr_n;
  wire start  = convst & ~convst_q & ~busy;

  always_comb begin
    cur = '0;
    for (int i = CH - 1; i >= 0; i--)
      if (pend[i]) cur = IW'(i);
  end

  assign pend_nxt = pend & ~(CH'(1) << cur);
  assign rd_data  = (rd_act && rptr < nres) ? res[rptr[IW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convst_q <= 1'b0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      convst_q <= convst;
      rd_q     <= rd_act;
      wr_q     <= wr_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_reg <= '1;
    else if (wr_act && !wr_q) sel_reg <= db_in[CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      eoc  <= 1'b0;
      hold <= '0;
      pend <= '0;
      tmr  <= '0;
      nres <= '0;
      for (int i = 0; i < CH; i++) begin
        smp[i] <= '0;
        res[i] <= '0;
      end
    end else begin
      eoc <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        hold <= '1;
        pend <= hw_sel ? sel_reg : sel_pin;
        tmr  <= '0;
        nres <= '0;
        for (int i = 0; i < CH; i++) smp[i] <= ch_in[i*DW +: DW];
      end else if (busy) begin
        if (pend == '0) begin
          busy <= 1'b0;
          hold <= '0;
        end else if (tmr == TLAST) begin
          tmr                <= '0;
          res[nres[IW-1:0]]  <= smp[cur];
          nres               <= nres + 1'b1;
          pend               <= pend_nxt;
          eoc                <= 1'b1;
          if (pend_nxt == '0) begin
            busy <= 1'b0;
            hold <= '0;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rptr <= '0;
    else if (start) rptr <= '0;
    else if (rd_q && !rd_act && rptr < nres) rptr <= rptr + 1'b1;
  end
endmodule

module simseq_ctrl_chk #(
  parameter int CH = 4,
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic [DW-1:0] rd_data,
  input logic          busy,
  input logic          eoc,
  input logic [CH-1:0] hold
);
  // R1
  hold_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> hold == {CH{1'b1}});
  // R4
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
  // R4
  eoc_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(busy));
  // R5
  track_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> hold == '0);
  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> rd_data == '0);
endmodule

bind simseq_ctrl simseq_ctrl_chk #(.CH(CH), .DW(DW)) u_chk (.*);

// File: tb/simseq_ctrl_bench.sv
module simseq_ctrl_bench;
  localparam int CH = 4, DW = 14, CONV = 12;

  logic clk = 0, rst_n = 0, convst = 0, hw_sel = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [CH-1:0] sel_pin = '0;
  logic [DW-1:0] db_in = '0;
  logic [CH*DW-1:0] ch_in = '0;
  logic [DW-1:0] rd_data;
  logic busy, eoc;
  logic [CH-1:0] hold;
  int checks = 0, errors = 0;

  simseq_ctrl #(.CH(CH), .DW(DW), .CONV_CYC(CONV)) u_simseq_ctrl (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CH*DW-1:0] pattern(input int seed);
    logic [CH*DW-1:0] v;
    for (int i = 0; i < CH; i++) v[i*DW +: DW] = DW'(seed * 613 + i * 2741 + 5);
    return v;
  endfunction

  task automatic wr_reg(input logic [3:0] v);
    @(negedge clk); cs_n = 0; wr_n = 0; db_in = DW'(v);
    @(negedge clk); cs_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic rd_one(input logic [DW-1:0] exp, input string req);
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk);
    chk(rd_data == exp, req, rd_data, exp);
    cs_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  // runs one sequence, expecting subset mask; optional mid-sequence start pulse and register write
  task automatic run_seq(input logic [3:0] mask, input int glitch, input bit do_wr,
                         input logic [3:0] wv, input string req);
    int n = $countones(mask);
    int blen = (n == 0) ? 1 : n * CONV;
    logic [CH*DW-1:0] orig = ch_in;
    @(negedge clk); convst = 1;
    for (int j = 0; j <= n * CONV + 3; j++) begin
      @(negedge clk);
      if (j == 0) begin convst = 0; ch_in = ~ch_in; sel_pin = ~sel_pin; end
      if (glitch > 0 && j == glitch) convst = 1;
      if (glitch > 0 && j == glitch + 1) convst = 0;
      if (do_wr && j == 2) begin cs_n = 0; wr_n = 0; db_in = DW'(wv); end
      if (do_wr && j == 3) begin cs_n = 1; wr_n = 1; end
      chk(busy == (j < blen), {req, " R1 R5 R7 busy"}, busy, j < blen);
      chk(eoc == (j > 0 && j % CONV == 0 && j <= n * CONV), {req, " R4 R6 eoc"}, eoc,
          j > 0 && j % CONV == 0 && j <= n * CONV);
      chk(hold == (j < blen ? 4'hF : 4'h0), {req, " R1 R5 hold"}, hold, j < blen ? 4'hF : 4'h0);
    end
    for (int i = 0; i < CH; i++)
      if (mask[i]) rd_one(orig[i*DW +: DW], {req, " R8 R9 result"});
    rd_one('0, {req, " R9 past end"});
  endtask

  task automatic t_reset();
    chk(busy == 0, "R11 busy", busy, 0);
    chk(eoc == 0, "R11 eoc", eoc, 0);
    chk(hold == 0, "R11 hold", hold, 0);
    chk(rd_data == 0, "R9 idle", rd_data, 0);
  endtask

  task automatic t_reg_default();   // R11 R2: register mode without a write converts all four
    hw_sel = 1; sel_pin = 4'b0001; ch_in = pattern(1);
    run_seq(4'b1111, 0, 0, 0, "R11 R2 default reg");
  endtask

  task automatic t_pins();          // R2 R3 R8: pins select channels 0 and 2
    hw_sel = 0; sel_pin = 4'b0101; ch_in = pattern(2);
    run_seq(4'b0101, 0, 0, 0, "R2 R3 pins");
  endtask

  task automatic t_reg_written();   // R10: written register overrides pins
    wr_reg(4'b1010);
    hw_sel = 1; sel_pin = 4'b0101; ch_in = pattern(3);
    run_seq(4'b1010, 0, 0, 0, "R10 reg");
  endtask

  task automatic t_empty();         // R6
    hw_sel = 0; sel_pin = 4'b0000; ch_in = pattern(4);
    run_seq(4'b0000, 0, 0, 0, "R6 empty");
  endtask

  task automatic t_glitch();        // R7: start pulse mid-sequence is ignored
    hw_sel = 0; sel_pin = 4'b0110; ch_in = pattern(5);
    run_seq(4'b0110, 5, 0, 0, "R7 restart");
  endtask

  task automatic t_wr_busy();       // R3 R10: write during busy affects only the next run
    hw_sel = 1; sel_pin = 4'b0000; ch_in = pattern(6);
    run_seq(4'b1010, 0, 1, 4'b0001, "R3 wr busy");
    hw_sel = 1; ch_in = pattern(7);
    run_seq(4'b0001, 0, 0, 0, "R10 next run");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reg_default();
    t_pins();
    t_reg_written();
    t_empty();
    t_glitch();
    t_wr_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule